// File: doc/BRIEF.md
# Reconfiguration Streaming Register Sequencer

This block is a small control engine that drives a transceiver reconfiguration management slave through its 6-bit word-addressed register port. A single start pulse launches a pass over every reconfiguration interface. There are twice as many interfaces as lanes. The lane channels come first, numbered 0 to LANES-1, and the transmit PLLs follow. For each interface the engine selects the logical channel and clears the mode field with a read-modify-write. It then stages the configuration image base address and launches that staging. Next it loads the stream-enable word and launches again. Finally it polls the busy flag until the streaming engine reports completion.

Each interface has its own 32-bit base address slice on a flat input vector. A slice left at zero selects the parameter default base. When the whole pass finishes, the block emits a one-cycle completion pulse. If busy never clears, a poll-count limit stops the pass and raises an error flag.

Top module: `reconf_stream_seq`

## Requirements
- R1: Interfaces are serviced in index order 0 to 2*LANES-1. Each interface begins with a write to word 0x38 whose data equals the interface index, with all bits above [9:0] zero.
- R2: Per interface, the writes are issued in this exact order: 0x38, 0x3A (mode clear), 0x3B=0, 0x3C=base, 0x3A (launch), 0x3B=1, 0x3C=3, 0x3A (launch). No other writes occur.
- R3: The mode clear writes 0x3A with the data returned by the immediately preceding read of 0x3A. Bits [3:2] are forced to 00 and every other bit is kept as read.
- R4: The base write to 0x3C carries the interface's slice `img_base[32*i +: 32]`. When that slice is zero, it carries the parameter DEF_BASE (default 32'h1000).
- R5: Each launch is a read of 0x3A followed by a write of the read value with bit [0] set and bits [3:2] at 00. No write to 0x3A ever has bits [3:2] non-zero.
- R6: After the second launch, 0x3A is read repeatedly. The next interface's 0x38 write happens only after a read returns bit [8] (busy) equal to 0.
- R7: While `m_wait` is high, a pending access holds its address, write data and strobes unchanged. A read finishes only when `m_rvalid` returns data. `m_wr` and `m_rd` are never high together.
- R8: If POLL_LIMIT consecutive polls all return busy, the pass aborts. No further access is issued, `err` rises and stays high until the next accepted start, and `done` is not pulsed. POLL_LIMIT-1 busy polls followed by a clear poll still succeed.
- R9: A start pulse that arrives while a pass is running is ignored. It causes no extra accesses and no second completion.
- R10: `done` is high for exactly one cycle, once per successful pass, after the last interface's busy poll has returned clear.
- R11: After synchronous reset, `m_wr`, `m_rd`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass when idle |
| img_base | input | 2*LANES*32 | Per-interface image base address, slice i for interface i; zero selects DEF_BASE |
| m_addr | output | 6 | Word address toward the management slave |
| m_wr | output | 1 | Write strobe |
| m_rd | output | 1 | Read strobe |
| m_wdata | output | 32 | Write data |
| m_wait | input | 1 | Slave stall; the access is held while high |
| m_rdata | input | 32 | Read data |
| m_rvalid | input | 1 | Read data valid |
| done | output | 1 | One-cycle pulse at the end of a successful pass |
| err | output | 1 | Poll timeout flag, cleared by the next accepted start |

## Verification
Two events can land in the same cycle. One is a poll result closing an interface. The other is either the poll limit running out, or a new start pulse arriving while the pass is busy. The bench makes busy clear on exactly the last permitted poll and holds busy forever in a second pass. In that second pass the judgement is success versus error, and a precise poll count. It also fires start in the middle of a pass while random wait states and read latencies shift the timing. Success is judged by an exact write log checked against the model, and by a single completion pulse.

// File: rtl/reconf_seq_pkg.sv
package reconf_seq_pkg;
  localparam logic [5:0] A_CHAN = 6'h38;
  localparam logic [5:0] A_CSR  = 6'h3A;
  localparam logic [5:0] A_OFS  = 6'h3B;
  localparam logic [5:0] A_DAT  = 6'h3C;
  localparam int BUSY_BIT  = 8;
  localparam int GO_BIT    = 0;
  localparam int MODE_LO   = 2;

  typedef enum logic [3:0] {
    ST_CHAN, ST_MODE_RD, ST_MODE_WR, ST_OFF0, ST_BASE,
    ST_GO1_RD, ST_GO1_WR, ST_OFF1, ST_CFG3, ST_GO2_RD, ST_GO2_WR, ST_POLL
  } step_e;

  typedef enum logic [1:0] {T_IDLE, T_ISSUE, T_WAIT} top_st_e;
endpackage

// File: rtl/reconf_mm_access.sv
module reconf_mm_access #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_rd,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ack,
  output logic [DW-1:0] ack_rdata,
  output logic [AW-1:0] m_addr,
  output logic          m_wr,
  output logic          m_rd,
  output logic [DW-1:0] m_wdata,
  input  logic          m_wait,
  input  logic [DW-1:0] m_rdata,
  input  logic          m_rvalid
);
  typedef enum logic [1:0] {B_IDLE, B_CMD, B_RDATA} bus_st_e;
  bus_st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= B_IDLE;
      m_addr    <= '0;
      m_wr      <= 1'b0;
      m_rd      <= 1'b0;
      m_wdata   <= '0;
      ack       <= 1'b0;
      ack_rdata <= '0;
    end else begin
      ack <= 1'b0;
      case (st)
        B_IDLE: if (req) begin
          m_addr  <= req_addr;
          m_wdata <= req_rd ? '0 : req_wdata;
          m_wr    <= !req_rd;
          m_rd    <= req_rd;
          st      <= B_CMD;
        end
        B_CMD: if (!m_wait) begin
          m_wr <= 1'b0;
          m_rd <= 1'b0;
          if (m_rd) st <= B_RDATA;
          else begin
            ack <= 1'b1;
            st  <= B_IDLE;
          end
        end
        B_RDATA: if (m_rvalid) begin
          ack_rdata <= m_rdata;
          ack       <= 1'b1;
          st        <= B_IDLE;
        end
        default: st <= B_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/reconf_poll_timer.sv
module reconf_poll_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/reconf_stream_seq.sv
module reconf_stream_seq
  import reconf_seq_pkg::*;
#(
  parameter int          LANES      = 2,
  parameter int          AW         = 6,
  parameter int          DW         = 32,
  parameter logic [31:0] DEF_BASE   = 32'h1000,
  parameter int          POLL_LIMIT = 1024
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [2*LANES*DW-1:0]  img_base,
  output logic [AW-1:0]          m_addr,
  output logic                   m_wr,
  output logic                   m_rd,
  output logic [DW-1:0]          m_wdata,
  input  logic                   m_wait,
  input  logic [DW-1:0]          m_rdata,
  input  logic                   m_rvalid,
  output logic                   done,
  output logic                   err
);
  localparam int NIF = 2 * LANES;
  localparam int IW  = (NIF > 1) ? $clog2(NIF) : 1;
  localparam logic [DW-1:0] MODE_MASK = DW'(3) << MODE_LO;
  localparam logic [DW-1:0] GO_MASK   = DW'(1) << GO_BIT;

  top_st_e       tst;
  step_e         step;
  logic [IW-1:0] idx;
  logic [DW-1:0] csr_img;

  logic [DW-1:0] base_arr [NIF];
  for (genvar g = 0; g < NIF; g++) begin : g_base
    assign base_arr[g] = (img_base[g*DW +: DW] == '0) ? DW'(DEF_BASE) : img_base[g*DW +: DW];
  end

  logic          req, req_rd, acc_ack;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, acc_rdata, base_cur, csr_clean;

  assign base_cur  = base_arr[idx];
  assign csr_clean = csr_img & ~MODE_MASK;
  assign req       = (tst == T_ISSUE);

  always_comb begin
    req_rd    = 1'b0;
    req_addr  = AW'(A_CSR);
    req_wdata = '0;
    case (step)
      ST_CHAN: begin
        req_addr  = AW'(A_CHAN);
        req_wdata = DW'(idx);
      end
      ST_MODE_RD, ST_GO1_RD, ST_GO2_RD, ST_POLL: req_rd = 1'b1;
      ST_MODE_WR: req_wdata = csr_clean;
      ST_GO1_WR, ST_GO2_WR: req_wdata = csr_clean | GO_MASK;
      ST_OFF0: req_addr = AW'(A_OFS);
      ST_OFF1: begin
        req_addr  = AW'(A_OFS);
        req_wdata = DW'(1);
      end
      ST_BASE: begin
        req_addr  = AW'(A_DAT);
        req_wdata = base_cur;
      end
      ST_CFG3: begin
        req_addr  = AW'(A_DAT);
        req_wdata = DW'(3);
      end
      default: ;
    endcase
  end

  reconf_mm_access #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst(rst),
    .req(req), .req_rd(req_rd), .req_addr(req_addr), .req_wdata(req_wdata),
    .ack(acc_ack), .ack_rdata(acc_rdata),
    .m_addr(m_addr), .m_wr(m_wr), .m_rd(m_rd), .m_wdata(m_wdata),
    .m_wait(m_wait), .m_rdata(m_rdata), .m_rvalid(m_rvalid)
  );

  logic poll_tick, poll_clr, poll_last, busy_now;
  assign busy_now  = acc_rdata[BUSY_BIT];
  assign poll_tick = (tst == T_WAIT) && acc_ack && (step == ST_POLL) && busy_now;
  assign poll_clr  = (tst == T_IDLE) || (step != ST_POLL);

  reconf_poll_timer #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst(rst), .clr(poll_clr), .tick(poll_tick), .last(poll_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tst     <= T_IDLE;
      step    <= ST_CHAN;
      idx     <= '0;
      csr_img <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (tst)
        T_IDLE: if (start) begin
          tst  <= T_ISSUE;
          step <= ST_CHAN;
          idx  <= '0;
          err  <= 1'b0;
        end
        T_ISSUE: tst <= T_WAIT;
        T_WAIT: if (acc_ack) begin
          tst <= T_ISSUE;
          if (step == ST_MODE_RD || step == ST_GO1_RD || step == ST_GO2_RD)
            csr_img <= acc_rdata;
          case (step)
            ST_CHAN:    step <= ST_MODE_RD;
            ST_MODE_RD: step <= ST_MODE_WR;
            ST_MODE_WR: step <= ST_OFF0;
            ST_OFF0:    step <= ST_BASE;
            ST_BASE:    step <= ST_GO1_RD;
            ST_GO1_RD:  step <= ST_GO1_WR;
            ST_GO1_WR:  step <= ST_OFF1;
            ST_OFF1:    step <= ST_CFG3;
            ST_CFG3:    step <= ST_GO2_RD;
            ST_GO2_RD:  step <= ST_GO2_WR;
            ST_GO2_WR:  step <= ST_POLL;
            ST_POLL: begin
              if (!busy_now) begin
                if (idx == IW'(NIF - 1)) begin
                  done <= 1'b1;
                  tst  <= T_IDLE;
                end else begin
                  idx  <= idx + 1'b1;
                  step <= ST_CHAN;
                end
              end else if (poll_last) begin
                err <= 1'b1;
                tst <= T_IDLE;
              end
            end
            default: step <= ST_CHAN;
          endcase
        end
        default: tst <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/reconf_stream_seq_chk.sv
module reconf_stream_seq_chk #(
  parameter int NIF = 4,
  parameter int AW  = 6,
  parameter int DW  = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] m_addr,
  input logic          m_wr,
  input logic          m_rd,
  input logic [DW-1:0] m_wdata,
  input logic          m_wait,
  input logic          done,
  input logic          err
);
  p_hold_req_r7: assert property (@(posedge clk) disable iff (rst)
    (m_wr || m_rd) && m_wait |=> $stable(m_addr) && $stable(m_wdata) && $stable(m_wr) && $stable(m_rd));

  p_no_dual_strobe_r7: assert property (@(posedge clk) disable iff (rst) !(m_wr && m_rd));

  p_chan_index_r1: assert property (@(posedge clk) disable iff (rst)
    m_wr && (m_addr == AW'(6'h38)) |-> (m_wdata < DW'(NIF)));

  p_mode_zero_r5: assert property (@(posedge clk) disable iff (rst)
    m_wr && (m_addr == AW'(6'h3A)) |-> (m_wdata[3:2] == 2'b00));

  p_done_single_r10: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  p_done_not_err_r8: assert property (@(posedge clk) disable iff (rst) !(done && err));
endmodule

bind reconf_stream_seq reconf_stream_seq_chk #(.NIF(2*LANES), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .m_addr(m_addr), .m_wr(m_wr), .m_rd(m_rd),
  .m_wdata(m_wdata), .m_wait(m_wait), .done(done), .err(err)
);

// File: tb/test_reconf_stream_seq.sv
`timescale 1ns/1ps
module test_reconf_stream_seq;
  localparam int LANES = 2;
  localparam int NIF   = 2 * LANES;
  localparam int PLIM  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [NIF*32-1:0] img_base = '0;
  logic [5:0]        m_addr;
  logic              m_wr, m_rd, done, err;
  logic [31:0]       m_wdata;
  logic              m_wait = 1'b0;
  logic [31:0]       m_rdata = '0;
  logic              m_rvalid = 1'b0;

  always #5 clk = ~clk;

  reconf_stream_seq #(.LANES(LANES), .POLL_LIMIT(PLIM)) i_reconf_stream_seq (
    .clk(clk), .rst(rst), .start(start), .img_base(img_base),
    .m_addr(m_addr), .m_wr(m_wr), .m_rd(m_rd), .m_wdata(m_wdata),
    .m_wait(m_wait), .m_rdata(m_rdata), .m_rvalid(m_rvalid),
    .done(done), .err(err)
  );

  int n_tests = 0, n_fail = 0;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // slave model state
  logic [31:0] st_csr;
  int  wr_k, poll_cnt, busy_left, busy_fix, done_cnt, rd_delay, last_ofs;
  bit  hang, stream_act, rd_pend, wait_en, prev_hold, prev_done;
  logic [5:0]  p_addr;
  logic [31:0] p_wdata;
  logic        p_wr, p_rd;

  function automatic logic [37:0] exp_write(int k, logic [31:0] csr, logic [NIF*32-1:0] bases);
    int ifc = k / 8;
    logic [31:0] b, cl;
    if (ifc >= NIF) return {6'h3F, 32'hDEAD_BEEF};
    b  = bases[ifc*32 +: 32];
    cl = csr & ~32'hC;
    case (k % 8)
      0: return {6'h38, 32'(ifc)};
      1: return {6'h3A, cl};
      2: return {6'h3B, 32'd0};
      3: return {6'h3C, (b == 0) ? 32'h1000 : b};
      4: return {6'h3A, cl | 32'h1};
      5: return {6'h3B, 32'd1};
      6: return {6'h3C, 32'd3};
      default: return {6'h3A, cl | 32'h1};
    endcase
  endfunction

  function automatic string tag_of(int k);
    case (k % 8)
      0: return "R1 channel write";
      1: return "R3 mode clear";
      2, 3: return "R4 base staging";
      5, 6: return "R2 stream setup";
      default: return "R5 launch";
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      logic [37:0] e;
      bit w;
      if (prev_hold)
        chk(m_addr == p_addr && m_wdata == p_wdata && m_wr == p_wr && m_rd == p_rd,
            "R7 hold under wait", {m_wr, m_rd, m_addr, m_wdata}, {p_wr, p_rd, p_addr, p_wdata});
      if (m_wr && m_rd) chk(0, "R7 dual strobe", 1, 0);
      m_rvalid = 1'b0;
      if (rd_pend) begin
        if (rd_delay == 0) begin
          rd_pend  = 0;
          m_rvalid = 1'b1;
          m_rdata  = st_csr;
          if (stream_act) begin
            poll_cnt++;
            if (hang || busy_left > 0) begin
              m_rdata[8] = 1'b1;
              if (!hang) busy_left--;
            end else stream_act = 0;
          end
        end else rd_delay--;
      end
      w = wait_en && ($urandom % 3 == 0);
      m_wait = w;
      if (m_wr && !w) begin
        e = exp_write(wr_k, st_csr, img_base);
        chk({m_addr, m_wdata} == e, tag_of(wr_k), {m_addr, m_wdata}, e);
        if (m_addr == 6'h38 && stream_act) chk(0, "R6 advanced while busy", 1, 0);
        if (m_addr == 6'h3B) last_ofs = int'(m_wdata[15:0]);
        if (m_addr == 6'h3A) begin
          st_csr = m_wdata & ~32'h101;
          if (m_wdata[0] && last_ofs == 1) begin
            stream_act = 1;
            busy_left  = (busy_fix >= 0) ? busy_fix : int'($urandom % 4);
          end
        end
        wr_k++;
      end
      if (m_rd && !w) begin
        if (rd_pend) chk(0, "R7 overlapping read", 1, 0);
        rd_pend  = 1;
        rd_delay = wait_en ? int'($urandom % 3) : 0;
      end
      prev_hold = (m_wr || m_rd) && w;
      p_addr = m_addr; p_wdata = m_wdata; p_wr = m_wr; p_rd = m_rd;
      if (done) begin
        done_cnt++;
        chk(wr_k == 8*NIF && !stream_act, "R10 done after last poll", wr_k, 8*NIF);
      end
      if (done && prev_done) chk(0, "R10 done wider than one cycle", 1, 0);
      prev_done = done;
    end
  end

  task automatic run(bit hng, bit glitch, int bfix, bit wen);
    int cyc;
    @(negedge clk); #1;
    for (int i = 0; i < NIF; i++)
      img_base[i*32 +: 32] = ($urandom % 3 == 0) ? 32'h0 : ($urandom & 32'hFFFF_FFF0);
    st_csr = $urandom & ~32'h101;
    st_csr[3:2] = 2'b11;
    wr_k = 0; poll_cnt = 0; done_cnt = 0; last_ofs = -1;
    hang = hng; busy_fix = bfix; wait_en = wen; stream_act = 0;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    @(negedge clk); #1;
    chk(err == 1'b0, "R8 err cleared by start", err, 0);
    cyc = 0;
    while (done_cnt == 0 && !err && cyc < 20000) begin
      @(negedge clk); #1;
      cyc++;
      if (glitch && cyc == 40) start = 1'b1;
      if (glitch && cyc == 41) start = 1'b0;
    end
    chk(cyc < 20000, "watchdog", cyc, 20000);
    repeat (60) @(negedge clk);
    #1;
    if (hng) begin
      chk(err == 1'b1, "R8 err raised", err, 1);
      chk(done_cnt == 0, "R8 no done on timeout", done_cnt, 0);
      chk(poll_cnt == PLIM, "R8 poll count", poll_cnt, PLIM);
      chk(wr_k == 8 && !m_wr && !m_rd, "R8 bus quiet after abort", wr_k, 8);
    end else begin
      chk(done_cnt == 1, glitch ? "R9 single done with extra start" : "R10 single done", done_cnt, 1);
      chk(wr_k == 8*NIF, glitch ? "R9 no extra writes" : "R2 write count", wr_k, 8*NIF);
      chk(err == 1'b0, "R8 no err on success", err, 0);
      if (bfix >= 0)
        chk(poll_cnt == NIF*(bfix+1), "R6 poll until clear", poll_cnt, NIF*(bfix+1));
    end
  endtask

  initial begin
    void'($urandom(32'd20240517));
    wait_en = 0; prev_hold = 0; prev_done = 0; rd_pend = 0; busy_fix = -1; hang = 0;
    wr_k = 0; done_cnt = 0; poll_cnt = 0; st_csr = '0; stream_act = 0; last_ofs = -1;
    repeat (3) @(negedge clk);
    chk(!m_wr && !m_rd && !done && !err, "R11 reset state", {m_wr, m_rd, done, err}, 0);
    rst = 1'b0;
    run(0, 0, 1, 0);          // directed, no stalls
    run(0, 1, -1, 1);         // start while running
    run(0, 0, PLIM-1, 1);     // busy clears on final permitted poll
    run(1, 0, -1, 1);         // busy never clears
    run(0, 0, 0, 1);          // err clears, immediate non-busy
    for (int r = 0; r < 5; r++) run(0, r % 2, -1, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule